// File: doc/BRIEF.md
# Synchronous Slave FIFO Read Port

This block holds a small bank of independent FIFOs that an external master drains through a synchronous slave interface. All of it runs on one interface clock. A two-bit select picks the FIFO under access. Three active-low controls shape each access: a chip select, an output enable and a read strobe. The head word of the selected FIFO is always prefetched into an output register. Asserting output enable therefore puts that word on the bus at once, with no strobe.

A read takes effect on a rising edge only when chip select and read strobe are both low. Each such edge advances the selected FIFO by one word, and the following word is on the bus after that edge. Holding the strobe and output enable low gives a burst of one word per cycle. Output enable does nothing except drive the bus: when it is high, the data pins float. A registered empty flag reports on the selected FIFO.

Internal producers fill the FIFOs through a valid/ready push port. A push completes on an edge where `push_valid` and `push_ready` are both high. `push_ready` falls when the FIFO named by `push_sel` is full. A word offered while ready is low is dropped, and the producer must hold it until ready returns. The FIFO select must be stable before an access starts.

Top module: `sfr_read_port`

## Requirements
- R1: A word is removed only on a rising edge where `cs_n`=0 and `rd_n`=0. A low `rd_n` while `cs_n`=1 leaves the bus word unchanged.
- R2: Toggling `oe_n` with no valid read never changes the word later presented on the bus.
- R3: With a word in the selected FIFO and `oe_n`=0, `rd_data` shows the head word without any read strobe.
- R4: After an edge with a valid read on a non-empty FIFO, `rd_data` shows the next word of that FIFO.
- R5: Holding `cs_n`=0, `rd_n`=0 and `oe_n`=0 presents words N, N+1, N+2 on consecutive cycles.
- R6: `rd_drive` equals the inverse of `oe_n`. `rd_data` is high impedance while `oe_n`=1.
- R7: A read on an empty selected FIFO is ignored. The next pushed word becomes the head.
- R8: `sel_empty` (1 = empty) is registered from the word count of the FIFO selected at each edge. It therefore trails a push or pop by one cycle.
- R9: The output register loads from the newly selected FIFO on the first edge after `fifo_addr` changes. Activity in one FIFO leaves the others' contents untouched.
- R10: `push_ready` is 0 exactly when the FIFO named by `push_sel` holds DEPTH words. A push offered while not ready is discarded.
- R11: A push and a read on the same FIFO in the same cycle both take effect. When the pushed word becomes the head, it is presented on the next edge.
- R12: After reset all FIFOs are empty, `sel_empty`=1, `push_ready`=1 and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer offers a word |
| push_sel | input | 2 | FIFO the producer targets |
| push_data | input | 8 | Word offered by the producer |
| push_ready | output | 1 | Targeted FIFO has room |
| fifo_addr | input | 2 | FIFO selected for reading |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| rd_data | output | 8 | Tri-state data bus |
| rd_drive | output | 1 | High while the bus is driven |
| sel_empty | output | 1 | Registered empty flag of the selected FIFO |

## Verification
A push and a read can land on the same FIFO in the same cycle. The hard case is a FIFO holding one word: the pushed word becomes the head on that very edge. The bench provokes this by keeping the strobe low on a one-word FIFO while offering a push to it, and by offering a push to an empty FIFO while the strobe is low. It judges the result by the word on the bus on the next cycle and by the empty flag one cycle later.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef struct packed {
    logic empty;
    logic full;
  } lane_flags_t;
endpackage

// File: rtl/sfr_fifo_lane.sv
module sfr_fifo_lane
  import sfr_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output lane_flags_t  flags_o,
  output logic [W-1:0] head_next_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr, rd_idx;
  logic [CW-1:0] cnt;

  assign flags_o.empty = (cnt == '0);
  assign flags_o.full  = (cnt == CW'(DEPTH));

  // word that sits at the head after this edge, forwarding a same-cycle push
  assign rd_idx      = pop_i ? rptr + 1'b1 : rptr;
  assign head_next_o = (push_i && (wptr == rd_idx)) ? push_data_i : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_i) wptr <= wptr + 1'b1;
      if (pop_i)  rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !flags_o.empty); // R7
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !flags_o.full); // R10
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !pop_i |=> $stable(rptr)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) pop_i |=> rptr == AW'($past(rptr) + 1'b1)); // R4
endmodule

// File: rtl/sfr_out_stage.sv
module sfr_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] load_i,
  input  logic         oe_n,
  output logic [W-1:0] rd_data,
  output logic         rd_drive
);
  logic [W-1:0] head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head_q <= '0;
    else        head_q <= load_i;
  end

  assign rd_drive = ~oe_n;
  assign rd_data  = rd_drive ? head_q : {W{1'bz}};

  AST_BUS_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !rd_drive); // R6
endmodule

// File: rtl/sfr_read_port.sv
module sfr_read_port
  import sfr_pkg::*;
#(
  parameter int W      = 8,
  parameter int DEPTH  = 4,
  parameter int NFIFO  = 4,
  parameter int SW     = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [SW-1:0] push_sel,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  input  logic [SW-1:0] fifo_addr,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          rd_n,
  output logic [W-1:0]  rd_data,
  output logic          rd_drive,
  output logic          sel_empty
);
  lane_flags_t        flags [NFIFO];
  logic [W-1:0]       head_next [NFIFO];
  logic [NFIFO-1:0]   pop_vec, push_vec;
  logic               strobe;

  assign strobe     = ~cs_n & ~rd_n;
  assign push_ready = ~flags[push_sel].full;

  for (genvar i = 0; i < NFIFO; i++) begin : g_lane
    assign pop_vec[i]  = strobe && (fifo_addr == SW'(i)) && !flags[i].empty;
    assign push_vec[i] = push_valid && push_ready && (push_sel == SW'(i));

    sfr_fifo_lane #(.W(W), .DEPTH(DEPTH)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_vec[i]),
      .push_data_i (push_data),
      .pop_i       (pop_vec[i]),
      .flags_o     (flags[i]),
      .head_next_o (head_next[i])
    );
  end

  sfr_out_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (head_next[fifo_addr]),
    .oe_n     (oe_n),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_empty <= 1'b1;
    else        sel_empty <= flags[fifo_addr].empty;
  end

  AST_CS_GATES_READ: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> pop_vec == '0); // R1
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pop_vec)); // R1
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(push_vec)); // R10
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && flags[fifo_addr].empty) |-> pop_vec == '0); // R7
endmodule

// File: tb/sfr_read_port_tb.sv
module sfr_read_port_tb;
  typedef struct packed {
    logic [3:0] req;
    logic       pv;
    logic [1:0] ps;
    logic [7:0] pd;
    logic [1:0] a;
    logic       cs;
    logic       oe;
    logic       rd;
    logic       edrv;
    logic       dchk;
    logic [7:0] edat;
    logic       eemp;
    logic       erdy;
  } vec_t;

  // req, pv, ps, pd, addr, cs_n, oe_n, rd_n, exp drive, check data, exp data, exp empty, exp ready
  localparam vec_t TBL [30] = '{
    '{4'd10, 1'b1, 2'd0, 8'h11, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R10 push
    '{4'd10, 1'b1, 2'd0, 8'h22, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R8 lag
    '{4'd3,  1'b1, 2'd0, 8'h33, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0, 1'b1}, // R3 prefetch
    '{4'd1,  1'b0, 2'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0, 1'b1}, // R1 cs high
    '{4'd6,  1'b0, 2'd0, 8'h00, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R6 float
    '{4'd2,  1'b0, 2'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0, 1'b1}, // R2 oe no move
    '{4'd4,  1'b0, 2'd0, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, 1'b1}, // R4 single
    '{4'd5,  1'b0, 2'd0, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h33, 1'b0, 1'b1}, // R5 burst
    '{4'd8,  1'b0, 2'd0, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R8 still 0
    '{4'd8,  1'b0, 2'd0, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1}, // R8 now 1
    '{4'd7,  1'b1, 2'd0, 8'h44, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 1'b1, 1'b1}, // R7 + R11
    '{4'd7,  1'b0, 2'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1}, // R7 kept
    '{4'd9,  1'b1, 2'd2, 8'hA1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1}, // R9 isolation
    '{4'd9,  1'b1, 2'd2, 8'hA2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b1}, // R9 switch
    '{4'd5,  1'b1, 2'd2, 8'hA3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA2, 1'b0, 1'b1}, // R5
    '{4'd5,  1'b1, 2'd2, 8'hA4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA3, 1'b0, 1'b1}, // R5
    '{4'd5,  1'b0, 2'd2, 8'h00, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA4, 1'b0, 1'b1}, // R5
    '{4'd11, 1'b1, 2'd2, 8'hA5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b1}, // R11 bypass
    '{4'd9,  1'b0, 2'd0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1}, // R9 back
    '{4'd10, 1'b1, 2'd1, 8'hB1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R10
    '{4'd10, 1'b1, 2'd1, 8'hB2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R10
    '{4'd10, 1'b1, 2'd1, 8'hB3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R10
    '{4'd10, 1'b1, 2'd1, 8'hB4, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R10 full
    '{4'd10, 1'b1, 2'd1, 8'hB5, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R10 drop
    '{4'd4,  1'b0, 2'd1, 8'h00, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB2, 1'b0, 1'b1}, // R4
    '{4'd5,  1'b0, 2'd1, 8'h00, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB3, 1'b0, 1'b1}, // R5
    '{4'd5,  1'b0, 2'd1, 8'h00, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB4, 1'b0, 1'b1}, // R5
    '{4'd8,  1'b0, 2'd1, 8'h00, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R8
    '{4'd8,  1'b0, 2'd1, 8'h00, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1}, // R8
    '{4'd10, 1'b1, 2'd1, 8'hC1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC1, 1'b1, 1'b1}  // R10 B5 gone
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [1:0] push_sel = '0;
  logic [7:0] push_data = '0;
  logic       push_ready;
  logic [1:0] fifo_addr = '0;
  logic       cs_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] rd_data;
  logic       rd_drive;
  logic       sel_empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sfr_read_port u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_sel(push_sel),
    .push_data(push_data), .push_ready(push_ready), .fifo_addr(fifo_addr),
    .cs_n(cs_n), .oe_n(oe_n), .rd_n(rd_n), .rd_data(rd_data),
    .rd_drive(rd_drive), .sel_empty(sel_empty)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R12", "sel_empty", sel_empty, 1);
    check("R12", "push_ready", push_ready, 1);
    check("R6", "rd_drive idle", rd_drive, 0);
    oe_n = 1'b0;
    #1;
    check("R6", "rd_drive on", rd_drive, 1);
    check("R12", "rd_data", rd_data, 0);
    oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      push_valid = TBL[i].pv;
      push_sel   = TBL[i].ps;
      push_data  = TBL[i].pd;
      fifo_addr  = TBL[i].a;
      cs_n       = TBL[i].cs;
      oe_n       = TBL[i].oe;
      rd_n       = TBL[i].rd;
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", TBL[i].req, i), "rd_drive", rd_drive, TBL[i].edrv);
      if (TBL[i].dchk)
        check($sformatf("R%0d row %0d", TBL[i].req, i), "rd_data", rd_data, TBL[i].edat);
      check($sformatf("R%0d row %0d", TBL[i].req, i), "sel_empty", sel_empty, TBL[i].eemp);
      check($sformatf("R%0d row %0d", TBL[i].req, i), "push_ready", push_ready, TBL[i].erdy);
    end

    // R12: reset in mid-run clears every FIFO
    @(negedge clk);
    push_valid = 1'b0; cs_n = 1'b1; rd_n = 1'b1; oe_n = 1'b0; fifo_addr = 2'd2;
    rst_n = 1'b0;
    #1;
    check("R12", "sel_empty in reset", sel_empty, 1);
    check("R12", "rd_data in reset", rd_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R12", "fifo2 empty after reset", sel_empty, 1);
    // R7: strobe on the cleared FIFO, then push: the pushed word is the head
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    push_valid = 1'b1; push_sel = 2'd2; push_data = 8'h5A;
    @(negedge clk);
    push_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R7", "head after empty read", rd_data, 8'h5A);
    check("R8", "sel_empty after push", sel_empty, 0);

    finish_up();
  end
endmodule